// File: doc/BRIEF.md
# Half-Cycle Coded Tone Packet Transmitter

This block turns a stream of bytes into a one-bit baseband tone for a simplex radio link. Each tone half-cycle is either long or short, and the output level flips at the end of every half-cycle. Bytes arrive through a write port into a small transmit buffer. When the first byte lands in an idle block, the block keys the transmitter and plays a run of long half-cycles to cover the radio's start-up time.

After that warm-up the block sends packets back to back. Each packet is a fixed synchronising pattern followed by three byte slots. Every byte is coded as four groups of four half-cycles, and each group carries two bits. When fewer than three bytes are waiting as a packet begins, each empty slot is filled with long half-cycles. When a packet ends and the buffer is empty, the transmitter is keyed off.

Timing comes from a microsecond tick input. Half-cycle lengths, the warm-up length and the buffer depth are all parameters.

Top module: `hct_tone_tx`

## Requirements
- R1: After reset `tx_key`, `tone`, `full` and `overflow` are all 0, and they stay 0 for as long as nothing is written.
- R2: A write to an idle, empty block raises `tx_key`. The block then sends `PREAMBLE_HC` long half-cycles before the first packet, and `tone` is 0 when `tx_key` rises.
- R3: A long half-cycle lasts `LONG_TICKS` ticks of `us_tick` and a short one lasts `SHORT_TICKS` ticks. `tone` toggles at the end of each half-cycle. Without ticks, `tone` and `tx_key` hold.
- R4: Every packet opens with 14 half-cycles: one long, twelve shorts, then one long.
- R5: Each byte is sent as four groups, most significant bit pair first. The codes are 00 = LLSS, 01 = LSSL, 10 = SLLS and 11 = SSLL, with half-cycles listed in time order.
- R6: The number of bytes a packet carries (at most 3) is fixed from the buffer contents when its sync starts. Each empty slot is sent as sixteen long half-cycles.
- R7: While the buffer holds data at a packet boundary, the next packet's sync follows at once, with no extra half-cycles.
- R8: If the buffer is empty at a packet boundary, `tx_key` falls as the last half-cycle ends. `tone` is 0 whenever `tx_key` is 0.
- R9: The buffer keeps `DEPTH` bytes in write order, and `full` is 1 exactly when it holds `DEPTH` bytes.
- R10: A write while `full` is 1 is dropped and sets `overflow`, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle time-base pulse (1 us nominal) |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to queue |
| full | output | 1 | Buffer holds DEPTH bytes |
| overflow | output | 1 | Sticky dropped-write flag |
| tone | output | 1 | Coded tone level |
| tx_key | output | 1 | Transmitter key |

## Verification
The bench builds the block with `DEPTH` = 4, `LONG_TICKS` = 4, `SHORT_TICKS` = 2 and `PREAMBLE_HC` = 3, and holds `us_tick` high, so a long half-cycle is four clocks. With those values a full packet lasts under 200 cycles. That makes it practical to cover a filled buffer, a dropped write, partly padded packets and writes that arrive in the middle of a burst. One case stops the tick during a burst to show that the tone freezes.

// File: rtl/hct_pkg.sv
package hct_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_PRE,
        PH_SYNC,
        PH_DATA
    } hct_phase_e;

    localparam int SYNC_LEN = 14;
    localparam int SLOTS    = 3;

    // Bit k of the result is 1 when half-cycle k (time order) of the group is long.
    function automatic logic [3:0] group_pattern(input logic [1:0] pair);
        case (pair)
            2'b00:   group_pattern = 4'b0011; // L L S S
            2'b01:   group_pattern = 4'b1001; // L S S L
            2'b10:   group_pattern = 4'b0110; // S L L S
            default: group_pattern = 4'b1100; // S S L L
        endcase
    endfunction

endpackage

// File: rtl/hct_fifo.sv
module hct_fifo #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty,
    output logic             overflow
);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] count;
        logic          ovf;
    } fifo_state_t;

    fifo_state_t s_d, s_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic push, pop;

    assign full     = (s_q.count == CW'(DEPTH));
    assign empty    = (s_q.count == '0);
    assign count    = s_q.count;
    assign overflow = s_q.ovf;
    assign rd_data  = mem_q[s_q.rptr];

    always_comb begin
        s_d  = s_q;
        push = wr_en && !full;
        pop  = rd_en && !empty;
        if (push) begin
            s_d.wptr = (s_q.wptr == AW'(DEPTH - 1)) ? '0 : s_q.wptr + 1'b1;
        end
        if (pop) begin
            s_d.rptr = (s_q.rptr == AW'(DEPTH - 1)) ? '0 : s_q.rptr + 1'b1;
        end
        if (push && !pop) begin
            s_d.count = s_q.count + 1'b1;
        end else if (pop && !push) begin
            s_d.count = s_q.count - 1'b1;
        end
        if (wr_en && full) begin
            s_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem_q[s_q.wptr] <= wr_data;
        end
    end

endmodule

// File: rtl/hct_hc_timer.sv
module hct_hc_timer #(
    parameter int LONG_TICKS  = 500,
    parameter int SHORT_TICKS = 250,
    localparam int TW = $clog2(LONG_TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic us_tick,
    input  logic run,
    input  logic is_long,
    input  logic finish,
    output logic hc_done,
    output logic tone
);

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          tone;
    } tmr_state_t;

    tmr_state_t s_d, s_q;
    logic [TW-1:0] last_cnt;

    assign last_cnt = is_long ? TW'(LONG_TICKS - 1) : TW'(SHORT_TICKS - 1);
    assign hc_done  = run && us_tick && (s_q.cnt == last_cnt);
    assign tone     = s_q.tone;

    always_comb begin
        s_d = s_q;
        if (!run) begin
            s_d.cnt  = '0;
            s_d.tone = 1'b0;
        end else if (hc_done) begin
            s_d.cnt  = '0;
            s_d.tone = finish ? 1'b0 : ~s_q.tone;
        end else if (us_tick) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/hct_seq.sv
module hct_seq
    import hct_pkg::*;
#(
    parameter int PREAMBLE_HC = 64,
    parameter int CW          = 6,
    localparam int PW = $clog2(PREAMBLE_HC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hc_done,
    input  logic          fifo_empty,
    input  logic [CW-1:0] fifo_count,
    input  logic [7:0]    rd_data,
    output logic          rd_en,
    output logic          is_long,
    output logic          keyed,
    output logic          finish
);

    typedef struct packed {
        hct_phase_e  phase;
        logic [PW-1:0] pre_cnt;
        logic [3:0]  sync_idx;
        logic [1:0]  slot;
        logic [1:0]  grp;
        logic [1:0]  hc;
        logic [1:0]  avail;
        logic [7:0]  cur;
        logic        valid;
    } seq_state_t;

    seq_state_t s_d, s_q;
    logic       start_pkt, load_slot;
    logic [1:0] pair, avail_now;
    logic [3:0] pat;

    assign keyed = (s_q.phase != PH_IDLE);

    always_comb begin
        case (s_q.grp)
            2'd0:    pair = s_q.cur[7:6];
            2'd1:    pair = s_q.cur[5:4];
            2'd2:    pair = s_q.cur[3:2];
            default: pair = s_q.cur[1:0];
        endcase
        pat = group_pattern(pair);
        avail_now = (fifo_count >= CW'(SLOTS)) ? 2'(SLOTS) : 2'(fifo_count);
    end

    always_comb begin
        case (s_q.phase)
            PH_SYNC: is_long = (s_q.sync_idx == 4'd0) || (s_q.sync_idx == 4'(SYNC_LEN - 1));
            PH_DATA: is_long = s_q.valid ? pat[s_q.hc] : 1'b1;
            default: is_long = 1'b1;
        endcase
    end

    always_comb begin
        s_d       = s_q;
        rd_en     = 1'b0;
        finish    = 1'b0;
        start_pkt = 1'b0;
        load_slot = 1'b0;
        case (s_q.phase)
            PH_IDLE: begin
                if (!fifo_empty) begin
                    s_d.phase   = PH_PRE;
                    s_d.pre_cnt = '0;
                end
            end
            PH_PRE: begin
                if (hc_done) begin
                    if (s_q.pre_cnt == PW'(PREAMBLE_HC - 1)) begin
                        start_pkt = 1'b1;
                    end else begin
                        s_d.pre_cnt = s_q.pre_cnt + 1'b1;
                    end
                end
            end
            PH_SYNC: begin
                if (hc_done) begin
                    if (s_q.sync_idx == 4'(SYNC_LEN - 1)) begin
                        s_d.phase = PH_DATA;
                        s_d.slot  = '0;
                        s_d.grp   = '0;
                        s_d.hc    = '0;
                        load_slot = 1'b1;
                    end else begin
                        s_d.sync_idx = s_q.sync_idx + 1'b1;
                    end
                end
            end
            default: begin
                if (hc_done) begin
                    s_d.hc = s_q.hc + 1'b1;
                    if (s_q.hc == 2'd3) begin
                        s_d.grp = s_q.grp + 1'b1;
                        if (s_q.grp == 2'd3) begin
                            if (s_q.slot == 2'(SLOTS - 1)) begin
                                start_pkt = 1'b1;
                            end else begin
                                s_d.slot  = s_q.slot + 1'b1;
                                load_slot = 1'b1;
                            end
                        end
                    end
                end
            end
        endcase

        if (start_pkt) begin
            if (fifo_empty) begin
                s_d.phase = PH_IDLE;
                finish    = 1'b1;
            end else begin
                s_d.phase    = PH_SYNC;
                s_d.sync_idx = '0;
                s_d.avail    = avail_now;
            end
        end

        if (load_slot) begin
            if (s_q.avail != 2'd0) begin
                rd_en     = 1'b1;
                s_d.cur   = rd_data;
                s_d.valid = 1'b1;
                s_d.avail = s_q.avail - 1'b1;
            end else begin
                s_d.valid = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/hct_tone_tx.sv
module hct_tone_tx #(
    parameter int DEPTH       = 32,
    parameter int LONG_TICKS  = 500,
    parameter int SHORT_TICKS = 250,
    parameter int PREAMBLE_HC = 64,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       us_tick,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic       full,
    output logic       overflow,
    output logic       tone,
    output logic       tx_key
);

    logic          rd_en, empty, hc_done, is_long, finish;
    logic [7:0]    rd_data;
    logic [CW-1:0] count;

    hct_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .count    (count),
        .full     (full),
        .empty    (empty),
        .overflow (overflow)
    );

    hct_seq #(.PREAMBLE_HC(PREAMBLE_HC), .CW(CW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .hc_done    (hc_done),
        .fifo_empty (empty),
        .fifo_count (count),
        .rd_data    (rd_data),
        .rd_en      (rd_en),
        .is_long    (is_long),
        .keyed      (tx_key),
        .finish     (finish)
    );

    hct_hc_timer #(.LONG_TICKS(LONG_TICKS), .SHORT_TICKS(SHORT_TICKS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .us_tick (us_tick),
        .run     (tx_key),
        .is_long (is_long),
        .finish  (finish),
        .hc_done (hc_done),
        .tone    (tone)
    );

endmodule

// File: rtl/hct_tone_tx_chk.sv
module hct_tone_tx_chk #(
    parameter int LONG_TICKS = 500,
    localparam int KW = $clog2(LONG_TICKS + 2) + 1
) (
    input logic clk,
    input logic rst_n,
    input logic us_tick,
    input logic wr_en,
    input logic full,
    input logic overflow,
    input logic tone,
    input logic tx_key
);

    logic          tone_p, key_p;
    logic [KW-1:0] ticks_q;
    logic          edge_seen;

    assign edge_seen = (tone != tone_p) || (tx_key != key_p);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tone_p  <= 1'b0;
            key_p   <= 1'b0;
            ticks_q <= '0;
        end else begin
            tone_p <= tone;
            key_p  <= tx_key;
            if (edge_seen) begin
                ticks_q <= (us_tick && tx_key) ? KW'(1) : '0;
            end else if (us_tick && tx_key && ticks_q <= KW'(LONG_TICKS)) begin
                ticks_q <= ticks_q + 1'b1;
            end
        end
    end

    AST_HC_MAX_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        ticks_q <= KW'(LONG_TICKS)); // R3

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_key && !us_tick) |=> ($stable(tone) && tx_key)); // R3

    AST_KEY_OFF_TONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_key |-> !tone); // R8

    AST_KEY_RISE_TONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_key) |-> !tone); // R2

    AST_DROP_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full) |=> overflow); // R10

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow); // R10

endmodule

bind hct_tone_tx hct_tone_tx_chk #(.LONG_TICKS(LONG_TICKS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .us_tick  (us_tick),
    .wr_en    (wr_en),
    .full     (full),
    .overflow (overflow),
    .tone     (tone),
    .tx_key   (tx_key)
);

// File: tb/test_hct_tone_tx.sv
module test_hct_tone_tx;

    localparam int DEPTH = 4;
    localparam int LT    = 4;
    localparam int ST    = 2;
    localparam int PRE   = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       us_tick = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       full, overflow, tone, tx_key;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit mon_on = 1'b1;
    bit exp_q[$];
    string req_q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc++;

    hct_tone_tx #(
        .DEPTH(DEPTH), .LONG_TICKS(LT), .SHORT_TICKS(ST), .PREAMBLE_HC(PRE)
    ) i_hct_tone_tx (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .wr_en(wr_en),
        .wr_data(wr_data), .full(full), .overflow(overflow),
        .tone(tone), .tx_key(tx_key)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // ---------------- driver side: expected half-cycle stream ----------------
    task automatic exp_push(input bit lng, input string req);
        exp_q.push_back(lng);
        req_q.push_back(req);
    endtask

    task automatic exp_pre();
        for (int i = 0; i < PRE; i++) exp_push(1'b1, "R2");
    endtask

    task automatic exp_packet(input logic [7:0] b0, input logic [7:0] b1,
                              input logic [7:0] b2, input int n, input string req);
        logic [7:0] b [3];
        b[0] = b0; b[1] = b1; b[2] = b2;
        exp_push(1'b1, "R4");
        for (int i = 0; i < 12; i++) exp_push(1'b0, "R4");
        exp_push(1'b1, "R4");
        for (int s = 0; s < 3; s++) begin
            for (int g = 0; g < 4; g++) begin
                logic [1:0] p;
                p = b[s][7-2*g -: 2];
                if (s >= n) begin
                    for (int h = 0; h < 4; h++) exp_push(1'b1, "R6");
                end else begin
                    case (p)
                        2'b00: begin exp_push(1,req); exp_push(1,req); exp_push(0,req); exp_push(0,req); end
                        2'b01: begin exp_push(1,req); exp_push(0,req); exp_push(0,req); exp_push(1,req); end
                        2'b10: begin exp_push(0,req); exp_push(1,req); exp_push(1,req); exp_push(0,req); end
                        default: begin exp_push(0,req); exp_push(0,req); exp_push(1,req); exp_push(1,req); end
                    endcase
                end
            end
        end
    endtask

    task automatic write_byte(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
    endtask

    task automatic end_write();
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        int n;
        n = 0;
        while (!tx_key && n < 20) begin @(negedge clk); n++; end
        n = 0;
        while (tx_key && n < 5000) begin @(negedge clk); n++; end
        chk(!tx_key, "R8 key off when drained", tx_key, 0);
        chk(exp_q.size() == 0, {tag, " all half-cycles sent"}, exp_q.size(), 0);
        @(negedge clk);
        chk(tone == 1'b0, "R8 tone low while unkeyed", tone, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // ---------------- monitor: measure half-cycles, compare with queue ----------------
    initial begin
        bit pk, pt, e;
        int last;
        string r;
        pk = 0; pt = 0; last = 0;
        forever begin
            @(negedge clk);
            if (mon_on && rst_n) begin
                if ((tx_key != pk) || (tx_key && tone != pt)) begin
                    if (pk) begin
                        if (exp_q.size() == 0) begin
                            chk(1'b0, "R8 unexpected half-cycle", cyc - last, 0);
                        end else begin
                            e = exp_q.pop_front();
                            r = req_q.pop_front();
                            chk((cyc - last) == (e ? LT : ST), {r, " half-cycle length (R3)"},
                                cyc - last, e ? LT : ST);
                        end
                    end
                    last = cyc;
                end
            end
            pk = tx_key;
            pt = tone;
        end
    end

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        int t0;
        bit tn;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_key == 0, "R1 key after reset", tx_key, 0);
        chk(tone == 0, "R1 tone after reset", tone, 0);
        chk(full == 0, "R1 full after reset", full, 0);
        chk(overflow == 0, "R1 overflow after reset", overflow, 0);
        repeat (20) @(negedge clk);
        chk(tx_key == 0, "R1 stays idle without data", tx_key, 0);

        // single byte, two padded slots
        exp_pre();
        exp_packet(8'hB4, 8'h00, 8'h00, 1, "R5");
        write_byte(8'hB4);
        end_write();
        @(negedge clk);
        chk(tx_key == 1, "R2 key raised after write", tx_key, 1);
        wait_idle("R6");

        // three bytes, one full packet with every group code
        exp_pre();
        exp_packet(8'h00, 8'hFF, 8'h5A, 3, "R5");
        write_byte(8'h00); write_byte(8'hFF); write_byte(8'h5A);
        end_write();
        wait_idle("R5");

        // fill buffer, one dropped write, two packets
        exp_pre();
        exp_packet(8'h11, 8'h22, 8'h33, 3, "R9");
        exp_packet(8'h44, 8'h00, 8'h00, 1, "R7");
        write_byte(8'h11); write_byte(8'h22); write_byte(8'h33); write_byte(8'h44);
        @(negedge clk);
        chk(full == 1, "R9 full at DEPTH bytes", full, 1);
        chk(overflow == 0, "R10 no overflow before drop", overflow, 0);
        wr_en = 1'b1; wr_data = 8'h99;
        end_write();
        chk(overflow == 1, "R10 overflow on dropped write", overflow, 1);
        wait_idle("R7");
        chk(overflow == 1, "R10 overflow sticky", overflow, 1);
        chk(full == 0, "R9 full clears when drained", full, 0);
        do_reset();
        @(negedge clk);
        chk(overflow == 0, "R10 overflow cleared by reset", overflow, 0);

        // writes during a packet join the next packet
        exp_pre();
        exp_packet(8'hC3, 8'h3C, 8'hA5, 3, "R6");
        exp_packet(8'hE7, 8'h18, 8'h00, 2, "R7");
        write_byte(8'hC3); write_byte(8'h3C); write_byte(8'hA5);
        end_write();
        t0 = cyc;
        while (cyc < t0 + 60) @(negedge clk);
        write_byte(8'hE7); write_byte(8'h18);
        end_write();
        wait_idle("R7");

        // tick held low freezes the tone
        mon_on = 1'b0;
        write_byte(8'h6C);
        end_write();
        while (!tx_key) @(negedge clk);
        repeat (5) @(negedge clk);
        us_tick = 1'b0;
        @(negedge clk);
        tn = tone;
        repeat (40) @(negedge clk);
        chk(tone == tn, "R3 tone holds without tick", tone, tn);
        chk(tx_key == 1, "R3 key holds without tick", tx_key, 1);
        us_tick = 1'b1;
        while (tx_key) @(negedge clk);
        chk(tone == 0, "R8 tone low after key off", tone, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule